// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block keeps the interrupt state of one processor over a space of 256 vectors. It holds three bitmaps: requests waiting for service, vectors currently in service, and a per-vector trigger-mode flag that marks level-sensitive sources. It also holds an 8-bit task priority and derives a processor priority from it. Vectors are grouped into priority classes of 16, and the class is the upper nibble of the vector. The highest waiting request is offered to the processor only when its class is above the processor priority.

An upstream source presents requests on the accept port. The processor takes the offered vector with an acknowledge strobe. It retires the most urgent in-service vector with an end-of-interrupt strobe. When the retired vector came from a level-sensitive source, the block pulses a broadcast output that carries the vector, so that the source can re-arm. Task priority can be written as a full byte or as a 4-bit class value.

Top module: `prio_vec_ctrl`

## Requirements
- R1: After reset all three bitmaps are empty and the task priority is 0. The outputs are then `irq_pending`=0, `proc_prio`=0, `task_prio`=0, `acc_taken`=0 and `eoi_bcast`=0.
- R2: An edge request (`acc_level`=0) on an enabled controller sets the vector's request bit and clears its trigger-mode bit. `acc_taken` is 1 in the next cycle only if the request bit was clear before.
- R3: A level request (`acc_level`=1) on a vector whose request bit is already set is discarded. The request and trigger-mode bits stay unchanged and `acc_taken` is 0. A level request on a vector that is not pending sets both bits.
- R4: A request is dropped with `acc_taken`=0 unless both `hw_en` and `sw_en` are 1. Vectors below 16 are reserved and are always dropped.
- R5: `irq_pending` is 1 only when a request is waiting and (highest request vector AND 0xF0) is strictly greater than `proc_prio`. `irq_vector` then shows that highest vector.
- R6: With H the highest in-service vector (0 when none is in service), `proc_prio` equals `task_prio` when task_prio[7:4] >= H[7:4]. Otherwise it equals H AND 0xF0.
- R7: `ack` while `irq_pending`=1 moves `irq_vector` from the request bitmap to the in-service bitmap. `ack` while `irq_pending`=0 changes nothing.
- R8: `eoi` clears the highest in-service vector. If that vector's trigger-mode bit was 1, the bit is cleared, and in the next cycle `eoi_bcast` is 1 for one cycle with `eoi_bcast_vec` equal to the vector. Otherwise `eoi_bcast` stays 0.
- R9: `eoi` while no vector is in service has no effect on any bitmap or output.
- R10: `tpr_wr` loads `task_prio` with `tpr_wdata`. `tpr_class_wr` loads task_prio[7:4] with `tpr_class_wdata` and clears task_prio[3:0]. The full-byte write wins when both are strobed together. `task_class` always reads task_prio[7:4].
- R11: When strobes meet in one cycle, the clears from `ack` (request bit) and `eoi` (in-service and trigger-mode bits) apply before the sets from an accepted request. Discard and newness are judged on the bitmaps as they stood before the cycle.
- R12: Every strobe takes effect at the next clock edge. `irq_pending`, `irq_vector` and `proc_prio` reflect it in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Hardware enable |
| sw_en | input | 1 | Software enable |
| acc_valid | input | 1 | Request strobe |
| acc_vec | input | 8 | Request vector |
| acc_level | input | 1 | 1 = level-sensitive, 0 = edge |
| acc_taken | output | 1 | Request newly set as pending (one cycle later) |
| ack | input | 1 | Processor takes the offered vector |
| eoi | input | 1 | End of interrupt |
| tpr_wr | input | 1 | Full task priority write |
| tpr_wdata | input | 8 | Task priority value |
| tpr_class_wr | input | 1 | Task priority class write |
| tpr_class_wdata | input | 4 | Task priority class value |
| irq_pending | output | 1 | A deliverable vector is offered |
| irq_vector | output | 8 | Offered vector |
| proc_prio | output | 8 | Processor priority |
| task_prio | output | 8 | Task priority |
| task_class | output | 4 | Upper nibble of task priority |
| eoi_bcast | output | 1 | Level-source end-of-interrupt pulse |
| eoi_bcast_vec | output | 8 | Vector of that pulse |

## Verification
Two pairs of functions can fall in the same cycle and touch the same vector. In the first, an acknowledge pulls a vector out of the request bitmap while a new request for that vector arrives. In the second, an end of interrupt clears a trigger-mode bit that a new request rewrites. The bench provokes both on purpose: it acknowledges 0x71 while re-requesting 0x71, and it retires a level vector while a fresh level request for it arrives. A long random phase then strobes all inputs at once. A behavioural model with plain arrays applies the clear-before-set order of R11, and the bench compares every output against it on every cycle.

// File: rtl/prio_vec_pkg.sv
package prio_vec_pkg;
   localparam int unsigned VEC_BITS   = 8;
   localparam int unsigned CLASS_BITS = 4;
   typedef logic [VEC_BITS-1:0] vec_t;
endpackage

// File: rtl/prio_enc.sv
module prio_enc #(
   parameter int unsigned WIDTH = 256,
   localparam int unsigned IW   = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] bits_in,
   output logic             found,
   output logic [IW-1:0]    index
);
   if (WIDTH < 2) begin : g_bad_width
      $error("prio_enc: WIDTH must be at least 2");
   end

   always_comb begin
      found = 1'b0;
      index = '0;
      for (int i = 0; i < WIDTH; i++) begin
         if (bits_in[i]) begin
            found = 1'b1;
            index = i[IW-1:0];
         end
      end
   end
endmodule

// File: rtl/prio_calc.sv
module prio_calc #(
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned CLASS_LSB = 4
) (
   input  logic [VEC_W-1:0] tpr,
   input  logic             svc_found,
   input  logic [VEC_W-1:0] svc_top,
   output logic [VEC_W-1:0] ppr
);
   localparam logic [VEC_W-1:0] CMASK = ~((VEC_W'(1) << CLASS_LSB) - VEC_W'(1));

   logic [VEC_W-1:0] svc_eff;

   always_comb begin
      svc_eff = svc_found ? svc_top : '0;
      if ((tpr & CMASK) >= (svc_eff & CMASK)) ppr = tpr;
      else                                   ppr = svc_eff & CMASK;
   end
endmodule

// File: rtl/prio_vec_ctrl.sv
module prio_vec_ctrl
   import prio_vec_pkg::*;
#(
   parameter int unsigned VEC_W     = VEC_BITS,
   parameter int unsigned CLASS_LSB = VEC_BITS - CLASS_BITS,
   parameter int unsigned RSVD_VEC  = 16,
   localparam int unsigned NUM_VEC  = 1 << VEC_W,
   localparam int unsigned CLS_W    = VEC_W - CLASS_LSB
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hw_en,
   input  logic             sw_en,
   input  logic             acc_valid,
   input  logic [VEC_W-1:0] acc_vec,
   input  logic             acc_level,
   output logic             acc_taken,
   input  logic             ack,
   input  logic             eoi,
   input  logic             tpr_wr,
   input  logic [VEC_W-1:0] tpr_wdata,
   input  logic             tpr_class_wr,
   input  logic [CLS_W-1:0] tpr_class_wdata,
   output logic             irq_pending,
   output logic [VEC_W-1:0] irq_vector,
   output logic [VEC_W-1:0] proc_prio,
   output logic [VEC_W-1:0] task_prio,
   output logic [CLS_W-1:0] task_class,
   output logic             eoi_bcast,
   output logic [VEC_W-1:0] eoi_bcast_vec
);
   localparam logic [VEC_W-1:0] CMASK = ~((VEC_W'(1) << CLASS_LSB) - VEC_W'(1));
   localparam logic [NUM_VEC-1:0] ONE = NUM_VEC'(1);

   if (CLASS_LSB == 0 || CLASS_LSB >= VEC_W) begin : g_bad_class
      $error("prio_vec_ctrl: CLASS_LSB out of range");
   end
   if (RSVD_VEC >= NUM_VEC) begin : g_bad_rsvd
      $error("prio_vec_ctrl: RSVD_VEC exceeds vector space");
   end

   logic [NUM_VEC-1:0] req_q, svc_q, lvl_q;
   logic [VEC_W-1:0]   tpr_q;

   logic             req_found, svc_found;
   logic [VEC_W-1:0] req_top, svc_top;

   prio_enc #(.WIDTH(NUM_VEC)) u_req_enc (
      .bits_in(req_q), .found(req_found), .index(req_top)
   );
   prio_enc #(.WIDTH(NUM_VEC)) u_svc_enc (
      .bits_in(svc_q), .found(svc_found), .index(svc_top)
   );

   prio_calc #(.VEC_W(VEC_W), .CLASS_LSB(CLASS_LSB)) u_prio (
      .tpr(tpr_q), .svc_found(svc_found), .svc_top(svc_top), .ppr(proc_prio)
   );

   logic deliver;
   always_comb begin
      deliver = req_found && (req_top >= VEC_W'(RSVD_VEC))
                && ((req_top & CMASK) > proc_prio);
   end

   assign irq_pending = deliver;
   assign irq_vector  = deliver ? req_top : '0;
   assign task_prio   = tpr_q;
   assign task_class  = tpr_q[VEC_W-1:CLASS_LSB];

   // Request acceptance
   logic enabled, acc_ok, was_pending, acc_drop, acc_set;
   logic [NUM_VEC-1:0] acc_mask;
   always_comb begin
      enabled     = hw_en & sw_en;
      acc_ok      = acc_valid && enabled && (acc_vec >= VEC_W'(RSVD_VEC));
      was_pending = req_q[acc_vec];
      acc_drop    = acc_level && was_pending;
      acc_set     = acc_ok && !acc_drop;
      acc_mask    = acc_set ? (ONE << acc_vec) : '0;
   end

   // Acknowledge and end-of-interrupt masks
   logic [NUM_VEC-1:0] ack_mask, eoi_mask;
   logic eoi_hit, eoi_lvl;
   always_comb begin
      ack_mask = (ack && deliver) ? (ONE << req_top) : '0;
      eoi_hit  = eoi && svc_found;
      eoi_mask = eoi_hit ? (ONE << svc_top) : '0;
      eoi_lvl  = eoi_hit && lvl_q[svc_top];
   end

   // Next state: clears first, then sets
   logic [NUM_VEC-1:0] req_d, svc_d, lvl_d;
   logic [VEC_W-1:0]   tpr_d;
   always_comb begin
      req_d = (req_q & ~ack_mask) | acc_mask;
      svc_d = (svc_q | ack_mask) & ~eoi_mask;
      lvl_d = lvl_q & ~eoi_mask & ~acc_mask;
      if (acc_level) lvl_d = lvl_d | acc_mask;
      if (tpr_wr)            tpr_d = tpr_wdata;
      else if (tpr_class_wr) tpr_d = {tpr_class_wdata, {CLASS_LSB{1'b0}}};
      else                   tpr_d = tpr_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q         <= '0;
         svc_q         <= '0;
         lvl_q         <= '0;
         tpr_q         <= '0;
         acc_taken     <= 1'b0;
         eoi_bcast     <= 1'b0;
         eoi_bcast_vec <= '0;
      end else begin
         req_q         <= req_d;
         svc_q         <= svc_d;
         lvl_q         <= lvl_d;
         tpr_q         <= tpr_d;
         acc_taken     <= acc_set && !was_pending;
         eoi_bcast     <= eoi_lvl;
         eoi_bcast_vec <= eoi_lvl ? svc_top : '0;
      end
   end
endmodule

// File: rtl/prio_vec_ctrl_chk.sv
module prio_vec_ctrl_chk #(
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned CLASS_LSB = 4,
   parameter int unsigned RSVD_VEC  = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hw_en,
   input logic             sw_en,
   input logic             acc_valid,
   input logic [VEC_W-1:0] acc_vec,
   input logic             acc_taken,
   input logic             eoi,
   input logic             irq_pending,
   input logic [VEC_W-1:0] irq_vector,
   input logic [VEC_W-1:0] proc_prio,
   input logic [VEC_W-1:0] task_prio,
   input logic             eoi_bcast
);
   localparam logic [VEC_W-1:0] CMASK = ~((VEC_W'(1) << CLASS_LSB) - VEC_W'(1));

   AST_NO_RSVD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pending |-> (irq_vector >= VEC_W'(RSVD_VEC))); // R4
   AST_CLASS_ABOVE_PPR: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pending |-> ((irq_vector & CMASK) > proc_prio)); // R5
   AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      proc_prio >= task_prio); // R6
   AST_TAKEN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      acc_taken |-> $past(acc_valid && hw_en && sw_en && (acc_vec >= VEC_W'(RSVD_VEC)))); // R4
   AST_BCAST_AFTER_EOI: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_bcast |-> $past(eoi)); // R8
   AST_BCAST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_bcast |=> !eoi_bcast || $past(eoi)); // R8
endmodule

bind prio_vec_ctrl prio_vec_ctrl_chk #(
   .VEC_W(VEC_W), .CLASS_LSB(CLASS_LSB), .RSVD_VEC(RSVD_VEC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
   .acc_valid(acc_valid), .acc_vec(acc_vec), .acc_taken(acc_taken),
   .eoi(eoi), .irq_pending(irq_pending), .irq_vector(irq_vector),
   .proc_prio(proc_prio), .task_prio(task_prio), .eoi_bcast(eoi_bcast)
);

// File: tb/tb_prio_vec_ctrl.sv
module tb_prio_vec_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hw_en = 0, sw_en = 0, acc_valid = 0, acc_level = 0;
   logic [7:0] acc_vec = 0;
   logic ack = 0, eoi = 0, tpr_wr = 0, tpr_class_wr = 0;
   logic [7:0] tpr_wdata = 0;
   logic [3:0] tpr_class_wdata = 0;
   logic acc_taken, irq_pending, eoi_bcast;
   logic [7:0] irq_vector, proc_prio, task_prio, eoi_bcast_vec;
   logic [3:0] task_class;

   always #10 clk = ~clk;

   prio_vec_ctrl dut (
      .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
      .acc_valid(acc_valid), .acc_vec(acc_vec), .acc_level(acc_level),
      .acc_taken(acc_taken), .ack(ack), .eoi(eoi),
      .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata),
      .tpr_class_wr(tpr_class_wr), .tpr_class_wdata(tpr_class_wdata),
      .irq_pending(irq_pending), .irq_vector(irq_vector),
      .proc_prio(proc_prio), .task_prio(task_prio), .task_class(task_class),
      .eoi_bcast(eoi_bcast), .eoi_bcast_vec(eoi_bcast_vec)
   );

   int n_checks = 0;
   int n_fail = 0;

   // Behavioural model
   bit m_req[256];
   bit m_svc[256];
   bit m_lvl[256];
   int m_tpr = 0;
   bit m_taken = 0;
   bit m_bc = 0;
   int m_bcv = 0;

   function automatic int top_of(input int which);
      for (int i = 255; i >= 0; i--) begin
         if (which == 0 && m_req[i]) return i;
         if (which == 1 && m_svc[i]) return i;
      end
      return -1;
   endfunction

   function automatic int m_ppr();
      int h = top_of(1);
      if (h < 0) h = 0;
      if ((m_tpr / 16) >= (h / 16)) return m_tpr;
      return (h / 16) * 16;
   endfunction

   function automatic int m_offer();
      int r = top_of(0);
      if (r >= 16 && (r / 16) * 16 > m_ppr()) return r;
      return -1;
   endfunction

   task automatic model_step();
      bit nreq[256];
      bit nsvc[256];
      bit nlvl[256];
      int dv = m_offer();
      int h = top_of(1);
      nreq = m_req; nsvc = m_svc; nlvl = m_lvl;
      m_taken = 0; m_bc = 0; m_bcv = 0;
      if (ack && dv >= 0) begin nreq[dv] = 0; nsvc[dv] = 1; end
      if (eoi && h >= 0) begin
         nsvc[h] = 0;
         if (m_lvl[h]) begin nlvl[h] = 0; m_bc = 1; m_bcv = h; end
      end
      if (acc_valid && hw_en && sw_en && acc_vec >= 16) begin
         if (!(acc_level && m_req[acc_vec])) begin
            nreq[acc_vec] = 1;
            nlvl[acc_vec] = acc_level;
            m_taken = !m_req[acc_vec];
         end
      end
      if (tpr_wr) m_tpr = tpr_wdata;
      else if (tpr_class_wr) m_tpr = tpr_class_wdata * 16;
      m_req = nreq; m_svc = nsvc; m_lvl = nlvl;
   endtask

   task automatic chk(input string req, input string what, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, got, exp, $time);
      end
   endtask

   task automatic compare_all();
      int ov = m_offer();
      chk("R5", "irq_pending", int'(irq_pending), int'(ov >= 0));
      if (ov >= 0) chk("R5", "irq_vector", int'(irq_vector), ov);
      chk("R6", "proc_prio", int'(proc_prio), m_ppr());
      chk("R10", "task_prio", int'(task_prio), m_tpr);
      chk("R10", "task_class", int'(task_class), m_tpr / 16);
      chk("R2", "acc_taken", int'(acc_taken), int'(m_taken));
      chk("R8", "eoi_bcast", int'(eoi_bcast), int'(m_bc));
      if (m_bc) chk("R8", "eoi_bcast_vec", int'(eoi_bcast_vec), m_bcv);
   endtask

   task automatic idle();
      acc_valid = 0; ack = 0; eoi = 0; tpr_wr = 0; tpr_class_wr = 0;
   endtask

   // Apply current inputs for one clock (R12: results sampled next negedge)
   task automatic cycle();
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare_all();
      idle();
   endtask

   task automatic req(input int v, input bit lvl);
      acc_valid = 1; acc_vec = 8'(v); acc_level = lvl;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R12 watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "irq_pending", int'(irq_pending), 0);
      chk("R1", "proc_prio", int'(proc_prio), 0);
      chk("R1", "task_prio", int'(task_prio), 0);
      chk("R1", "eoi_bcast", int'(eoi_bcast), 0);
      chk("R1", "acc_taken", int'(acc_taken), 0);
      // R4: disabled controller drops
      hw_en = 1; sw_en = 0; req(8'h40, 0); cycle();
      chk("R4", "dropped while disabled", int'(irq_pending), 0);
      sw_en = 1;
      // R9: eoi with empty in-service set
      eoi = 1; cycle();
      // R4: reserved vector
      req(8'h0A, 0); cycle();
      chk("R4", "reserved vector", int'(irq_pending), 0);
      // R2: edge request
      req(8'h35, 0); cycle();
      chk("R2", "taken edge", int'(acc_taken), 1);
      // R3: level then repeated level
      req(8'h52, 1); cycle();
      req(8'h52, 1); cycle();
      chk("R3", "repeat level discarded", int'(acc_taken), 0);
      // R10 and R5: priority gate
      tpr_wr = 1; tpr_wdata = 8'h60; cycle();
      chk("R5", "gated by tpr", int'(irq_pending), 0);
      tpr_class_wr = 1; tpr_class_wdata = 4'h4; cycle();
      chk("R10", "class write", int'(task_prio), 8'h40);
      tpr_wr = 1; tpr_wdata = 8'h47; tpr_class_wr = 1; tpr_class_wdata = 4'h9; cycle();
      // R7: ack moves 0x52 to service, ppr becomes 0x50
      ack = 1; cycle();
      chk("R6", "ppr from service", int'(proc_prio), 8'h50);
      // R11: ack and same-vector edge request together
      req(8'h71, 0); cycle();
      ack = 1; req(8'h71, 0); cycle();
      chk("R11", "re-pending not offered", int'(irq_pending), 0);
      // R7: ack with nothing offered
      ack = 1; cycle();
      // R8: eoi of edge 0x71, then level 0x52 with same-cycle level request
      eoi = 1; cycle();
      ack = 1; cycle();
      eoi = 1; cycle();
      eoi = 1; req(8'h52, 1); cycle();
      chk("R8", "level broadcast", int'(eoi_bcast), 1);
      // Random phase: all strobes at once
      for (int k = 0; k < 4000; k++) begin
         hw_en = ($urandom_range(0, 15) != 0);
         sw_en = ($urandom_range(0, 15) != 0);
         acc_valid = $urandom_range(0, 1);
         acc_vec = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 31))
                                               : 8'($urandom_range(0, 255));
         acc_level = $urandom_range(0, 1);
         ack = $urandom_range(0, 2) == 0;
         eoi = $urandom_range(0, 3) == 0;
         tpr_wr = $urandom_range(0, 40) == 0;
         tpr_wdata = 8'($urandom_range(0, 255));
         tpr_class_wr = $urandom_range(0, 40) == 0;
         tpr_class_wdata = 4'($urandom_range(0, 15));
         cycle();
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule